// File: doc/BRIEF.md
# Byte-Wide Configuration Register Loader with Auto-Addressing

This block holds a bank of nineteen 12-bit configuration registers for a video timing generator. Software or a small controller programs them over an 8-bit bus with a LOAD strobe. LOAD is asynchronous to the pixel clock. Two qualifier inputs travel with each strobe. One selects between an address cycle and a data cycle. The other selects the low byte or the high nibble of the target register. The qualifiers are sampled when LOAD falls, and the write is committed when LOAD rises.

An address cycle with the byte qualifier high enters auto mode. In auto mode, successive data cycles walk through the registers. The pointer advances only after a high-byte write. It wraps back to the first address loaded, not to zero.

An asynchronous, active-high clear returns every register to its default. A parameter selects whether the status register comes up with the clock-enable bit set. The whole bank is presented flat to the timing logic.

The controller is a four-state machine. The states are `ST_MAN_IDLE`, `ST_MAN_ARMED`, `ST_AUTO_IDLE` and `ST_AUTO_ARMED`. The transitions are:
- An IDLE state moves to its ARMED state when LOAD falls; the qualifiers are captured at that moment.
- An ARMED state returns to an IDLE state when LOAD rises. A data cycle keeps the current mode. An address cycle selects auto mode if its byte qualifier was 1, and manual mode otherwise.

Top module: `cfg_byte_loader`

## Requirements
- R1: While `clr` is high and after it is released, register 0 (status) reads 0x400 when `CLK_EN_AT_CLEAR` is 1 and 0x000 when it is 0. Every other register reads 0x000.
- R2: Qualifiers are sampled when `ld_strobe` falls, and no register changes before `ld_strobe` rises. A register written by a cycle holds its new value no later than three clock edges after the rise.
- R3: A data cycle (`ld_is_data`=1) with `ld_hi_byte`=0 writes bus bits 7:0 into register bits 7:0. With `ld_hi_byte`=1 it writes bus bits 3:0 into register bits 11:8. The other bits of the register are kept.
- R4: Bit 11 of register 0 always reads 0, whatever is written. Bit 10 of register 0 is clock enable and bit 9 disables equalization/serration; both are written normally.
- R5: In manual mode, a data cycle whose latched address is above 18 changes no register.
- R6: An address cycle (`ld_is_data`=0) loads the bus value as the pointer. It selects auto mode if `ld_hi_byte`=1 and manual mode if `ld_hi_byte`=0. In manual mode, data cycles never move the pointer.
- R7: In auto mode, each data cycle writes the register at the pointer. The pointer advances by one after a high-byte write and does not move after a low-byte write.
- R8: In auto mode, a high-byte write to register 18 returns the pointer to the start address of the last address cycle.
- R9: In auto mode with a start address of 18 or more, the pointer stays on that address. A start address above 18 therefore writes nothing.
- R10: `clr` acts without a clock edge. It also returns the loader to manual mode with pointer 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| clr | input | 1 | Asynchronous clear, active high |
| ld_strobe | input | 1 | Asynchronous load strobe; qualifiers sampled on fall, commit on rise |
| ld_is_data | input | 1 | 0 = address cycle, 1 = data cycle |
| ld_hi_byte | input | 1 | 0 = low byte, 1 = high nibble; on an address cycle 1 selects auto mode |
| ld_bus | input | 8 | Address or data byte |
| cfg_regs | output | 228 | Register bank, register i in bits 12*i+11 : 12*i |

## Verification
A corrupted pointer or base shows up on the first data cycle after it. The wrong register changes, or a register that should change does not, three clock edges after that strobe's rise. Sweeping every register in both modes therefore exposes it within one LOAD cycle. A wrong state (a lost auto flag or a missed arm) shows up as a write landing in the wrong slot, or no write at all, at the very next commit. The bank is compared in full before every rise and after it, so early writes are caught in the cycle they happen.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
    typedef enum logic [1:0] {
        ST_MAN_IDLE,
        ST_MAN_ARMED,
        ST_AUTO_IDLE,
        ST_AUTO_ARMED
    } ld_state_e;

    localparam int CLK_EN_BIT = 10;
    localparam int TEST_BIT   = 11;
endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic async_in,
    output logic rise_ev,
    output logic fall_ev
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or posedge clr) begin
        if (clr) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], async_in};
    end

    assign rise_ev = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall_ev = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/cfgl_ctrl.sv
module cfgl_ctrl
    import cfgl_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int NREG  = 19
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             fall_ev,
    input  logic             rise_ev,
    input  logic             is_data,
    input  logic             hi_byte,
    input  logic [BUS_W-1:0] bus,
    output logic             wr_en,
    output logic             wr_hi,
    output logic [BUS_W-1:0] wr_addr,
    output logic [BUS_W-1:0] wr_byte,
    output logic             auto_mode,
    output logic [BUS_W-1:0] base_addr
);
    localparam logic [BUS_W-1:0] LAST = BUS_W'(NREG - 1);

    ld_state_e        st_q, st_d;
    logic             q_data, q_hi;
    logic [BUS_W-1:0] ptr_q, base_q;
    logic             idle, armed, commit;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_MAN_IDLE:   if (fall_ev) st_d = ST_MAN_ARMED;
            ST_AUTO_IDLE:  if (fall_ev) st_d = ST_AUTO_ARMED;
            ST_MAN_ARMED:  if (rise_ev) st_d = (!q_data && q_hi) ? ST_AUTO_IDLE : ST_MAN_IDLE;
            ST_AUTO_ARMED: if (rise_ev) st_d = (q_data || q_hi) ? ST_AUTO_IDLE : ST_MAN_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or posedge clr) begin
        if (clr) st_q <= ST_MAN_IDLE;
        else     st_q <= st_d;
    end

    // outputs
    always_comb begin
        idle      = (st_q == ST_MAN_IDLE) || (st_q == ST_AUTO_IDLE);
        armed     = (st_q == ST_MAN_ARMED) || (st_q == ST_AUTO_ARMED);
        commit    = armed && rise_ev;
        wr_en     = commit && q_data;
        wr_hi     = q_hi;
        wr_addr   = ptr_q;
        wr_byte   = bus;
        auto_mode = (st_q == ST_AUTO_IDLE) || (st_q == ST_AUTO_ARMED);
        base_addr = base_q;
    end

    // qualifier capture and pointer
    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            q_data <= 1'b0;
            q_hi   <= 1'b0;
            ptr_q  <= '0;
            base_q <= '0;
        end else begin
            if (idle && fall_ev) begin
                q_data <= is_data;
                q_hi   <= hi_byte;
            end
            if (commit && !q_data) begin
                ptr_q  <= bus;
                base_q <= bus;
            end else if (wr_en && q_hi && st_q == ST_AUTO_ARMED) begin
                ptr_q <= (ptr_q >= LAST) ? base_q : ptr_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfgl_bank.sv
module cfgl_bank #(
    parameter int                 NREG       = 19,
    parameter int                 REG_W      = 12,
    parameter int                 BUS_W      = 8,
    parameter logic [REG_W-1:0]   STATUS_RST = '0,
    parameter logic [REG_W-1:0]   ZERO_MASK  = '0
) (
    input  logic                  clk,
    input  logic                  clr,
    input  logic                  wr_en,
    input  logic                  wr_hi,
    input  logic [BUS_W-1:0]      wr_addr,
    input  logic [BUS_W-1:0]      wr_byte,
    output logic [NREG*REG_W-1:0] regs
);
    localparam int HI_W = REG_W - BUS_W;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [REG_W-1:0] RST_V = (g == 0) ? STATUS_RST : '0;
        localparam logic [REG_W-1:0] CLR_M = (g == 0) ? ZERO_MASK  : '0;
        logic [REG_W-1:0] q, d;

        always_comb begin
            d = q;
            if (wr_en && wr_addr == BUS_W'(g)) begin
                if (wr_hi) d[REG_W-1:BUS_W] = wr_byte[HI_W-1:0];
                else       d[BUS_W-1:0]     = wr_byte;
            end
            d = d & ~CLR_M;
        end

        always_ff @(posedge clk or posedge clr) begin
            if (clr) q <= RST_V;
            else     q <= d;
        end

        assign regs[g*REG_W +: REG_W] = q;
    end
endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader
    import cfgl_pkg::*;
#(
    parameter int NREG            = 19,
    parameter int REG_W           = 12,
    parameter int BUS_W           = 8,
    parameter int SYNC_STAGES     = 2,
    parameter bit CLK_EN_AT_CLEAR = 1'b0
) (
    input  logic                  clk,
    input  logic                  clr,
    input  logic                  ld_strobe,
    input  logic                  ld_is_data,
    input  logic                  ld_hi_byte,
    input  logic [BUS_W-1:0]      ld_bus,
    output logic [NREG*REG_W-1:0] cfg_regs
);
    localparam logic [REG_W-1:0] STATUS_RST = CLK_EN_AT_CLEAR ? REG_W'(1) << CLK_EN_BIT : '0;
    localparam logic [REG_W-1:0] ZERO_MASK  = REG_W'(1) << TEST_BIT;

    logic             rise_ev, fall_ev;
    logic             wr_en, wr_hi, auto_mode;
    logic [BUS_W-1:0] wr_addr, wr_byte, base_addr;

    cfgl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .clr(clr), .async_in(ld_strobe),
        .rise_ev(rise_ev), .fall_ev(fall_ev)
    );

    cfgl_ctrl #(.BUS_W(BUS_W), .NREG(NREG)) u_ctrl (
        .clk(clk), .clr(clr), .fall_ev(fall_ev), .rise_ev(rise_ev),
        .is_data(ld_is_data), .hi_byte(ld_hi_byte), .bus(ld_bus),
        .wr_en(wr_en), .wr_hi(wr_hi), .wr_addr(wr_addr), .wr_byte(wr_byte),
        .auto_mode(auto_mode), .base_addr(base_addr)
    );

    cfgl_bank #(
        .NREG(NREG), .REG_W(REG_W), .BUS_W(BUS_W),
        .STATUS_RST(STATUS_RST), .ZERO_MASK(ZERO_MASK)
    ) u_bank (
        .clk(clk), .clr(clr), .wr_en(wr_en), .wr_hi(wr_hi),
        .wr_addr(wr_addr), .wr_byte(wr_byte), .regs(cfg_regs)
    );
endmodule

// File: rtl/cfgl_chk.sv
module cfgl_chk #(
    parameter int NREG  = 19,
    parameter int REG_W = 12,
    parameter int BUS_W = 8
) (
    input logic                  clk,
    input logic                  clr,
    input logic                  rise_ev,
    input logic                  wr_en,
    input logic                  wr_hi,
    input logic                  auto_mode,
    input logic [BUS_W-1:0]      wr_addr,
    input logic [BUS_W-1:0]      base_addr,
    input logic [NREG*REG_W-1:0] cfg_regs
);
    localparam logic [BUS_W-1:0] LAST = BUS_W'(NREG - 1);

    p_write_on_rise_r2: assert property (@(posedge clk) disable iff (clr)
        wr_en |-> rise_ev);

    p_bank_hold_r2: assert property (@(posedge clk) disable iff (clr)
        !$past(wr_en) |-> $stable(cfg_regs));

    p_test_bit_zero_r4: assert property (@(posedge clk) disable iff (clr)
        cfg_regs[11] == 1'b0);

    p_low_no_advance_r7: assert property (@(posedge clk) disable iff (clr)
        (wr_en && !wr_hi && auto_mode) |=> $stable(wr_addr));

    p_high_advance_r7: assert property (@(posedge clk) disable iff (clr)
        (wr_en && wr_hi && auto_mode && wr_addr < LAST) |=> (wr_addr == $past(wr_addr) + 1'b1));

    p_ptr_window_r8: assert property (@(posedge clk) disable iff (clr)
        (auto_mode && base_addr <= LAST) |-> (wr_addr >= base_addr && wr_addr <= LAST));

    p_ptr_parked_r9: assert property (@(posedge clk) disable iff (clr)
        (auto_mode && base_addr >= LAST) |-> (wr_addr == base_addr));
endmodule

bind cfg_byte_loader cfgl_chk #(.NREG(NREG), .REG_W(REG_W), .BUS_W(BUS_W)) u_chk (
    .clk(clk), .clr(clr), .rise_ev(rise_ev), .wr_en(wr_en), .wr_hi(wr_hi),
    .auto_mode(auto_mode), .wr_addr(wr_addr), .base_addr(base_addr),
    .cfg_regs(cfg_regs)
);

// File: tb/test_cfg_byte_loader.sv
module test_cfg_byte_loader;
    localparam int CLK_P = 10;
    localparam int NR    = 19;
    localparam int RW    = 12;

    logic clk = 1'b0;
    logic clr = 1'b1;
    logic ld_strobe = 1'b1, ld_is_data = 1'b0, ld_hi_byte = 1'b0;
    logic [7:0] ld_bus = '0;
    logic [NR*RW-1:0] regs_off, regs_on;

    int n_chk = 0, n_fail = 0;
    logic [RW-1:0] m [NR];
    int mptr, mbase;
    bit mauto;

    always #(CLK_P/2) clk = ~clk;

    cfg_byte_loader #(.CLK_EN_AT_CLEAR(1'b0)) i_cfg_byte_loader (
        .clk(clk), .clr(clr), .ld_strobe(ld_strobe), .ld_is_data(ld_is_data),
        .ld_hi_byte(ld_hi_byte), .ld_bus(ld_bus), .cfg_regs(regs_off));

    cfg_byte_loader #(.CLK_EN_AT_CLEAR(1'b1)) i_cfg_byte_loader_on (
        .clk(clk), .clr(clr), .ld_strobe(ld_strobe), .ld_is_data(ld_is_data),
        .ld_hi_byte(ld_hi_byte), .ld_bus(ld_bus), .cfg_regs(regs_on));

    function automatic logic [NR*RW-1:0] model_flat();
        logic [NR*RW-1:0] f;
        for (int i = 0; i < NR; i++) f[i*RW +: RW] = m[i];
        return f;
    endfunction

    task automatic check(string tag, logic [NR*RW-1:0] act, logic [NR*RW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NR; i++) m[i] = '0;
        mptr = 0; mbase = 0; mauto = 0;
    endtask

    task automatic clocks(int n);
        repeat (n) @(negedge clk);
    endtask

    // one full LOAD cycle; bank checked before the rise and after it
    task automatic do_load(bit ad, bit hb, logic [7:0] d, string tag);
        ld_is_data = ad; ld_hi_byte = hb; ld_bus = d;
        ld_strobe = 1'b0;
        clocks(4);
        check({"R2 no write before rise / ", tag}, regs_off, model_flat());
        ld_strobe = 1'b1;
        if (!ad) begin
            mptr = d; mbase = d; mauto = hb;
        end else begin
            if (mptr < NR) begin
                if (hb) m[mptr][11:8] = d[3:0];
                else    m[mptr][7:0]  = d;
                if (mptr == 0) m[0][11] = 1'b0;
            end
            if (mauto && hb) mptr = (mptr >= NR-1) ? mbase : mptr + 1;
        end
        clocks(4);
        check(tag, regs_off, model_flat());
    endtask

    initial begin
        #(CLK_P*150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [NR*RW-1:0] on_def;
        on_def = '0;
        on_def[10] = 1'b1;
        model_clear();

        // R1 reset defaults, both variants
        clocks(3);
        check("R1 default during clear, variant off", regs_off, '0);
        check("R1 default during clear, variant on", regs_on, on_def);
        clr = 1'b0;
        clocks(4);
        check("R1 default after clear, variant off", regs_off, '0);
        check("R1 default after clear, variant on", regs_on, on_def);

        // R3 R4 manual sweep of every register (57 LOAD cycles)
        for (int r = 0; r < NR; r++) begin
            do_load(1'b0, 1'b0, 8'(r), "R6 manual address");
            do_load(1'b1, 1'b0, 8'((r*37 + 11) & 255), "R3 low byte write");
            do_load(1'b1, 1'b1, 8'((r*29 + 200) & 255), "R3 high nibble write");
        end
        check("R4 status bit 11 reads 0", {{(NR*RW-1){1'b0}}, regs_off[11]}, '0);
        do_load(1'b0, 1'b0, 8'd0, "R6 manual address 0");
        do_load(1'b1, 1'b1, 8'hFF, "R4 high nibble all ones to status");
        check("R4 status bit 11 reads 0 after all-ones", {{(NR*RW-1){1'b0}}, regs_off[11]}, '0);

        // R5 manual writes above 18 ignored
        for (int a = 19; a < 24; a++) begin
            do_load(1'b0, 1'b0, 8'(a), "R5 out-of-range address");
            do_load(1'b1, 1'b0, 8'hAA, "R5 ignored low write");
            do_load(1'b1, 1'b1, 8'hFF, "R5 ignored high write");
        end
        do_load(1'b0, 1'b0, 8'd255, "R5 address 255");
        do_load(1'b1, 1'b0, 8'h55, "R5 ignored write at 255");

        // R7 R8 auto from 0 across all registers and wrap
        do_load(1'b0, 1'b1, 8'd0, "R6 enter auto at 0");
        for (int r = 0; r < NR; r++) begin
            do_load(1'b1, 1'b0, 8'((r*53 + 3) & 255), "R7 auto low byte");
            do_load(1'b1, 1'b1, 8'((r*7 + 1) & 255), "R7 auto high byte advances");
        end
        do_load(1'b1, 1'b0, 8'h11, "R8 wrap to start 0");
        do_load(1'b1, 1'b0, 8'h22, "R7 low byte does not advance");
        do_load(1'b1, 1'b1, 8'h03, "R7 high byte after two lows");

        // R8 wrap to a nonzero start
        do_load(1'b0, 1'b1, 8'd15, "R6 enter auto at 15");
        for (int k = 0; k < 6; k++) begin
            do_load(1'b1, 1'b0, 8'((k*41 + 9) & 255), "R8 auto low from 15");
            do_load(1'b1, 1'b1, 8'(k + 4), "R8 auto high from 15");
        end

        // R9 start at 18 parks, above 18 writes nothing
        do_load(1'b0, 1'b1, 8'd18, "R9 enter auto at 18");
        for (int k = 0; k < 3; k++) begin
            do_load(1'b1, 1'b0, 8'(k + 100), "R9 parked low at 18");
            do_load(1'b1, 1'b1, 8'(k + 9), "R9 parked high at 18");
        end
        do_load(1'b0, 1'b1, 8'd30, "R9 enter auto at 30");
        for (int k = 0; k < 2; k++) begin
            do_load(1'b1, 1'b0, 8'hC3, "R9 ignored low at 30");
            do_load(1'b1, 1'b1, 8'h0C, "R9 ignored high at 30");
        end

        // R6 back to manual: pointer stays put
        do_load(1'b0, 1'b0, 8'd5, "R6 manual at 5");
        do_load(1'b1, 1'b1, 8'h07, "R6 manual high no advance");
        do_load(1'b1, 1'b0, 8'h99, "R6 manual low same register");

        // R10 asynchronous clear between edges, then pointer 0 manual
        @(negedge clk);
        #(CLK_P/4);
        clr = 1'b1;
        #1;
        check("R10 clear without clock edge, variant off", regs_off, '0);
        check("R10 clear without clock edge, variant on", regs_on, on_def);
        clocks(2);
        clr = 1'b0;
        model_clear();
        clocks(4);
        do_load(1'b1, 1'b0, 8'h3C, "R10 pointer 0 after clear");
        do_load(1'b1, 1'b1, 8'h02, "R10 manual mode after clear");
        do_load(1'b1, 1'b0, 8'h4D, "R10 no advance after clear");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule